// File: doc/BRIEF.md
# Stream Fan-Out Splitter

The block takes one valid/ready stream and hands every item on it, unchanged, to a parameterised number of downstream valid/ready streams. The upstream item is retired only once every downstream port has taken its copy. It does no buffering and no payload transformation. It sits between a producer and several consumers that must all see the same sequence of items.

A build-time parameter selects between two schemes. In the lockstep scheme there is no state: all downstream ports show the item together, and the item moves only in a cycle where every consumer is ready at once. In the independent scheme each downstream port has a small two-state machine, so consumers can take the item in different cycles. `LANE_WAIT` means the lane still owes the current item to its consumer. `LANE_TAKEN` means the consumer already has it. A lane moves from `LANE_WAIT` to `LANE_TAKEN` on the *take* transition: its own handshake completes while the upstream item is not retired in the same cycle. It moves from `LANE_TAKEN` back to `LANE_WAIT` on the *rearm* transition, which happens when the upstream item is retired. This costs one flip-flop per port.

Top module: `stream_fanout`

## Requirements
- R1: Every downstream data slice `dn_data[k*DATA_W +: DATA_W]` equals `up_data` in every cycle, in both schemes.
- R2: After reset in the independent scheme, every lane is in `LANE_WAIT`. A valid upstream item is therefore shown on every downstream port, whatever lanes had taken before the reset.
- R3: In the lockstep scheme, every bit of `dn_valid` equals `up_valid` AND (all bits of `dn_ready` high).
- R4: In the lockstep scheme, `up_ready` equals the AND of all `dn_ready` bits.
- R5: In the independent scheme, `dn_valid[k]` equals `up_valid` AND (lane k is in `LANE_WAIT`).
- R6: In the independent scheme, `up_ready` equals the AND over all lanes k of (lane k in `LANE_TAKEN` OR `dn_ready[k]`).
- R7: In the independent scheme, an upstream retirement (`up_valid && up_ready`) returns every lane to `LANE_WAIT`. The next valid item is then shown on all ports.
- R8: In the independent scheme, a lane whose handshake completes without an upstream retirement in the same cycle drops its `dn_valid` from the next cycle on. The other lanes are unaffected.
- R9: While the upstream item is held valid, a raised `dn_valid[k]` stays high until port k has accepted the item.
- R10: Each upstream item is accepted exactly once on each downstream port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Upstream item present |
| up_ready | output | 1 | Upstream item retired this cycle when high with up_valid |
| up_data | input | DATA_W | Upstream payload |
| dn_valid | output | LANES | Per-port item present |
| dn_ready | input | LANES | Per-port consumer ready |
| dn_data | output | LANES*DATA_W | Per-port payload copies, port k in slice k |

## Verification
The bench runs a long pseudo-random sweep of ready patterns and upstream valid gaps against a three-port, eight-bit instance of each scheme. Every cycle it compares the outputs with an arithmetic model of the taken flags. A design that forgot to clear the flags on retirement would hide the next item from ports that took the previous one. A design that set a flag together with a retirement would lose an item on that port. Both would show up as valid mismatches and as per-port accept counts that differ from the retired-item count. A directed sequence drops one lane to `LANE_TAKEN` and then resets, so a reset that left flags set would keep that port silent. In lockstep, a design that raised valid on a partial ready pattern would let some consumers take an item twice, and the all-or-nothing valid check catches that.

// File: rtl/fork_pkg.sv
package fork_pkg;
    typedef enum logic {
        LANE_WAIT  = 1'b0,
        LANE_TAKEN = 1'b1
    } lane_state_t;
endpackage

// File: rtl/fork_lane.sv
module fork_lane
    import fork_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic item_valid,
    input  logic item_retire,
    input  logic lane_ready,
    output logic lane_valid,
    output logic lane_clear
);
    lane_state_t state_q;
    lane_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LANE_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LANE_WAIT:  if (!item_retire && item_valid && lane_ready) state_d = LANE_TAKEN;
            LANE_TAKEN: if (item_retire) state_d = LANE_WAIT;
        endcase
    end

    always_comb begin
        lane_valid = 1'b0;
        lane_clear = 1'b1;
        unique case (state_q)
            LANE_WAIT: begin
                lane_valid = item_valid;
                lane_clear = lane_ready;
            end
            LANE_TAKEN: begin
                lane_valid = 1'b0;
                lane_clear = 1'b1;
            end
        endcase
    end

    // R9: a pending copy is not withdrawn while the item is held
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_valid && !lane_ready) |=> (!item_valid || lane_valid));
    // R8: a lane that took the item goes quiet next cycle
    assert_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_valid && lane_ready && !item_retire) |=> !lane_valid);
    // R7: after retirement the lane shows the next item
    assert_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        item_retire |=> (lane_valid == item_valid));
endmodule

// File: rtl/stream_fanout.sv
module stream_fanout #(
    parameter int LANES    = 3,
    parameter int DATA_W   = 8,
    parameter bit LOCKSTEP = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    up_valid,
    output logic                    up_ready,
    input  logic [DATA_W-1:0]       up_data,
    output logic [LANES-1:0]        dn_valid,
    input  logic [LANES-1:0]        dn_ready,
    output logic [LANES*DATA_W-1:0] dn_data
);
    localparam logic [LANES-1:0] ALL_ONES = {LANES{1'b1}};

    logic up_fire;
    assign up_fire = up_valid && up_ready;

    for (genvar k = 0; k < LANES; k++) begin : g_copy
        assign dn_data[k*DATA_W +: DATA_W] = up_data;
    end

    if (LOCKSTEP) begin : g_lockstep
        logic all_ready;
        assign all_ready = (dn_ready == ALL_ONES);
        assign up_ready  = all_ready;
        assign dn_valid  = {LANES{up_valid && all_ready}};

        // R3: ports are either all presenting or all silent
        assert_together_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (dn_valid == '0) || (dn_valid == ALL_ONES));
    end else begin : g_indep
        logic [LANES-1:0] lane_clear;
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            fork_lane u_lane (
                .clk         (clk),
                .rst_n       (rst_n),
                .item_valid  (up_valid),
                .item_retire (up_fire),
                .lane_ready  (dn_ready[k]),
                .lane_valid  (dn_valid[k]),
                .lane_clear  (lane_clear[k])
            );
        end
        assign up_ready = (lane_clear == ALL_ONES);

        // R6: no port left waiting when the item retires
        assert_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
            up_fire |-> ((dn_valid & ~dn_ready) == '0));
        // R6: a stall always has a waiting, non-ready port behind it
        assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (up_valid && !up_ready) |-> ((dn_valid & ~dn_ready) != '0));
    end
endmodule

// File: tb/test_stream_fanout.sv
`timescale 1ns/1ps
module test_stream_fanout;
    localparam int N = 3;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic a_uv, a_ur, s_uv, s_ur;
    logic [W-1:0] a_ud, s_ud;
    logic [N-1:0] a_dv, a_dr, s_dv, s_dr;
    logic [N*W-1:0] a_dd, s_dd;

    stream_fanout #(.LANES(N), .DATA_W(W), .LOCKSTEP(1'b0)) i_stream_fanout (
        .clk(clk), .rst_n(rst_n), .up_valid(a_uv), .up_ready(a_ur), .up_data(a_ud),
        .dn_valid(a_dv), .dn_ready(a_dr), .dn_data(a_dd));

    stream_fanout #(.LANES(N), .DATA_W(W), .LOCKSTEP(1'b1)) i_stream_fanout_sync (
        .clk(clk), .rst_n(rst_n), .up_valid(s_uv), .up_ready(s_ur), .up_data(s_ud),
        .dn_valid(s_dv), .dn_ready(s_dr), .dn_data(s_dd));

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [N-1:0] m_done;
    logic prev_fire;
    logic [15:0] lfsr = 16'hACE1;
    int a_in_cnt = 0, s_in_cnt = 0;
    int a_lane_cnt [N];
    int s_lane_cnt [N];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        m_done = '0;
        prev_fire = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input logic [N-1:0] ar, input logic [N-1:0] sr);
        logic [N-1:0] exp_av, exp_sv;
        logic exp_ar, exp_sr, a_fire, s_fire;
        string vtag;
        @(negedge clk);
        a_dr = ar;
        s_dr = sr;
        #1;
        exp_av = {N{a_uv}} & ~m_done;
        exp_ar = ((m_done | ar) == {N{1'b1}});
        vtag = prev_fire ? "R7 rearm valid" : ((m_done != '0) ? "R8 taken valid" : "R5 async valid");
        chk(a_dv == exp_av, vtag, a_dv, exp_av);
        chk(a_ur == exp_ar, "R6 async up_ready", a_ur, exp_ar);
        exp_sr = (sr == {N{1'b1}});
        exp_sv = {N{s_uv && exp_sr}};
        chk(s_dv == exp_sv, "R3 lockstep valid", s_dv, exp_sv);
        chk(s_ur == exp_sr, "R4 lockstep up_ready", s_ur, exp_sr);
        for (int k = 0; k < N; k++) begin
            chk(a_dd[k*W +: W] == a_ud, "R1 async copy", a_dd[k*W +: W], a_ud);
            chk(s_dd[k*W +: W] == s_ud, "R1 lockstep copy", s_dd[k*W +: W], s_ud);
            if (a_dv[k] && ar[k]) a_lane_cnt[k]++;
            if (s_dv[k] && sr[k]) s_lane_cnt[k]++;
        end
        a_fire = a_uv && a_ur;
        s_fire = s_uv && s_ur;
        if (a_fire) a_in_cnt++;
        if (s_fire) s_in_cnt++;
        @(posedge clk);
        m_done = a_fire ? '0 : (m_done | (exp_av & ar));
        prev_fire = a_fire;
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (a_fire || !a_uv) begin
            a_uv = lfsr[7] | lfsr[9];
            if (a_fire) a_ud = a_ud + 8'd7;
        end
        if (s_fire || !s_uv) begin
            s_uv = lfsr[8] | lfsr[11];
            if (s_fire) s_ud = s_ud + 8'd5;
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < N; k++) begin
            a_lane_cnt[k] = 0;
            s_lane_cnt[k] = 0;
        end
        a_uv = 1'b1; s_uv = 1'b1;
        a_ud = 8'h10; s_ud = 8'h80;
        a_dr = '0; s_dr = '0;
        do_reset();
        #1;
        chk(a_dv == 3'b111, "R2 reset all lanes waiting", a_dv, 3'b111);
        chk(s_dv == 3'b000, "R3 lockstep no ready", s_dv, 3'b000);

        // R9: held item stays presented while nobody is ready
        step(3'b000, 3'b000);
        step(3'b000, 3'b000);
        chk(a_dv == 3'b111, "R9 valid held", a_dv, 3'b111);

        // sweep of ready patterns with pseudo-random valid gaps
        for (int i = 0; i < 3000; i++) begin
            step(lfsr[2:0] ^ lfsr[12:10], lfsr[5:3] | {2'b00, lfsr[14]});
        end

        for (int k = 0; k < N; k++) begin
            chk(a_lane_cnt[k] == a_in_cnt + int'(m_done[k]), "R10 async exactly once",
                a_lane_cnt[k], a_in_cnt + int'(m_done[k]));
            chk(s_lane_cnt[k] == s_in_cnt, "R10 lockstep exactly once", s_lane_cnt[k], s_in_cnt);
        end

        // directed: one lane taken, then reset must show the item on all ports
        do_reset();
        a_uv = 1'b1;
        step(3'b001, 3'b000);
        step(3'b000, 3'b000);
        chk(a_dv == 3'b110, "R8 lane0 taken", a_dv, 3'b110);
        do_reset();
        #1;
        chk(a_dv == 3'b111, "R2 reset clears taken", a_dv, 3'b111);
        step(3'b110, 3'b000);
        step(3'b001, 3'b000);
        step(3'b000, 3'b000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule